// File: doc/BRIEF.md
# Self-Correcting Redundant Register Field

This block is one control-register field whose every logical bit lives in five separate flip-flops. The value seen on the read port is the majority of the five copies: a bit reads as 1 when at least three copies hold 1. Every cycle the voted value is written back into all copies. Upsets in one or two copies of a bit are therefore masked at once and repaired on the next clock, without any report.

An extra check bit holds the even parity of the field. It is computed on every write and is stored and voted exactly like a data bit. If three or more copies of a data bit flip, the vote settles on the wrong value. If three or more copies of the check bit flip, the vote on the check bit goes wrong. In both cases the parity of the voted field stops matching the voted check bit. That mismatch is uncorrectable and sets a sticky alarm line, which the surrounding logic routes to its own error-signalling channel.

A small two-state machine holds the alarm. In `ALM_IDLE` the line is low. The transition *raise* (a mismatch is present) moves it to `ALM_SET`, where the line is high. The transition *release* (clear pulsed while no mismatch is present) moves it back to `ALM_IDLE`. In every other case the machine stays in its current state. A fault-injection port flips any chosen set of copies of one chosen bit for a single update, for test.

Top module: `rr_field`

## Requirements
- R1: Each logical bit, including the check bit, is held in five flip-flops, and `rd_data` bit i is 1 exactly when at least three copies of bit i hold 1.
- R2: When one or two copies of a bit are disturbed, `rd_data` keeps its correct value and `uncorr_err` stays low.
- R3: In any cycle with no write and no injection, every copy of every bit is loaded with its voted value. After two copies are flipped at one edge and two other copies of the same bit at the next edge, `rd_data` is still correct and no alarm is raised.
- R4: With `wr_en` high at an edge, all five copies of every data bit load `wr_data` instead of the scrubbed value, and `rd_data` equals that data right after the edge.
- R5: The check bit is the even parity of `wr_data`, that is the XOR of all its bits. It is loaded into its five copies on each write. Writing data of either parity raises no alarm.
- R6: When the XOR of the voted data bits differs from the voted check bit, `uncorr_err` goes high at the next clock edge. When three copies of a data bit flip, `rd_data` shows that bit inverted right after the injection edge.
- R7: `uncorr_err` is sticky. It falls at an edge only if `err_clr` is high and no mismatch is present. A clear at an edge where a mismatch is present leaves it high.
- R8: With `inj_en` high, each copy of bit `inj_sel` whose `inj_mask` bit is 1 stores the inverse of the value it would otherwise load, for that one edge only. Bits 0 to WIDTH-1 are the data bits, and index WIDTH is the check bit. This inversion also applies on top of a write in the same cycle.
- R9: After reset, `rd_data` equals the parameter `RST_VAL`, the check bit matches its parity, and `uncorr_err` is low.
- R10: When three copies of the check bit flip, `rd_data` is unchanged and `uncorr_err` rises at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Value to write |
| rd_data | output | WIDTH | Majority-voted field value |
| inj_en | input | 1 | Fault-injection enable |
| inj_sel | input | $clog2(WIDTH+1) | Target bit index (WIDTH selects the check bit) |
| inj_mask | input | 5 | Copies of the target bit to invert |
| err_clr | input | 1 | Clear request for the alarm |
| uncorr_err | output | 1 | Sticky uncorrectable-error alarm |

## Verification
The clear request and a fresh parity mismatch can meet at the same edge, and the release transition must lose to the raise condition there. The bench corrupts three copies of the check bit. In the very next cycle it writes a repairing value and pulses `err_clr` together, so the mismatch is present only for that one cycle. The alarm must still be high afterwards and fall only on a later, separate clear. A write and an injection landing together are also driven, and the result is judged by whether the injected copies stay within the correctable range.

// File: rtl/rr_pkg.sv
package rr_pkg;

    localparam int unsigned RR_COPIES = 5;

    typedef enum logic [0:0] {
        ALM_IDLE = 1'b0,
        ALM_SET  = 1'b1
    } alarm_state_e;

    function automatic int unsigned rr_popcount(input logic [RR_COPIES-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < RR_COPIES; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/rr_vote_cell.sv
module rr_vote_cell #(
    parameter int unsigned COPIES  = rr_pkg::RR_COPIES,
    parameter logic        RST_BIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic [COPIES-1:0] flip_mask,
    output logic              voted
);
    localparam int unsigned MAJ = COPIES / 2 + 1;

    logic [COPIES-1:0] copy_q;
    logic [COPIES-1:0] base_d;

    // majority of the stored copies
    always_comb begin
        voted = (rr_pkg::rr_popcount(copy_q) >= MAJ);
    end

    // write has priority over scrub-back
    always_comb begin
        base_d = wr_en ? {COPIES{wr_bit}} : {COPIES{voted}};
    end

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                copy_q[c] <= RST_BIT;
            end else begin
                copy_q[c] <= base_d[c] ^ flip_mask[c];
            end
        end
    end

    AST_SCRUB_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && flip_mask == '0) |=> (copy_q == '0 || copy_q == '1)) else $error("scrub"); // R3
    AST_SCRUB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && flip_mask == '0) |=> $stable(voted)) else $error("stable"); // R2
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && flip_mask == '0) |=> (voted == $past(wr_bit))) else $error("wr"); // R4

endmodule

// File: rtl/rr_inject_dec.sv
module rr_inject_dec #(
    parameter int unsigned NBITS  = 9,
    parameter int unsigned COPIES = rr_pkg::RR_COPIES,
    parameter int unsigned SELW   = 4
) (
    input  logic              inj_en,
    input  logic [SELW-1:0]   inj_sel,
    input  logic [COPIES-1:0] inj_mask,
    output logic [COPIES-1:0] flip [NBITS]
);
    for (genvar b = 0; b < NBITS; b++) begin : g_dec
        always_comb begin
            flip[b] = (inj_en && inj_sel == SELW'(b)) ? inj_mask : '0;
        end
    end
endmodule

// File: rtl/rr_alarm_fsm.sv
module rr_alarm_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic detect,
    input  logic err_clr,
    output logic alarm
);
    import rr_pkg::*;

    alarm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ALM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_IDLE: if (detect)              state_d = ALM_SET;  // raise
            ALM_SET:  if (err_clr && !detect)  state_d = ALM_IDLE; // release
            default:                           state_d = ALM_IDLE;
        endcase
    end

    always_comb begin
        alarm = (state_q == ALM_SET);
    end

    AST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        detect |=> alarm) else $error("raise"); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !err_clr) |=> alarm) else $error("sticky"); // R7
    AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && err_clr && detect) |=> alarm) else $error("clr"); // R7

endmodule

// File: rtl/rr_field.sv
module rr_field #(
    parameter int unsigned       WIDTH   = 8,
    parameter logic [WIDTH-1:0]  RST_VAL = 8'hA5,
    parameter int unsigned       SELW    = $clog2(WIDTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [WIDTH-1:0]             wr_data,
    output logic [WIDTH-1:0]             rd_data,
    input  logic                         inj_en,
    input  logic [SELW-1:0]              inj_sel,
    input  logic [rr_pkg::RR_COPIES-1:0] inj_mask,
    input  logic                         err_clr,
    output logic                         uncorr_err
);
    import rr_pkg::*;

    localparam int unsigned NBITS = WIDTH + 1;
    localparam logic [NBITS-1:0] RST_EXT = {^RST_VAL, RST_VAL};

    logic [NBITS-1:0]     wr_ext;
    logic [NBITS-1:0]     voted;
    logic [RR_COPIES-1:0] flip [NBITS];
    logic                 mismatch;

    always_comb begin
        wr_ext = {^wr_data, wr_data};
    end

    rr_inject_dec #(
        .NBITS  (NBITS),
        .COPIES (RR_COPIES),
        .SELW   (SELW)
    ) u_dec (
        .inj_en   (inj_en),
        .inj_sel  (inj_sel),
        .inj_mask (inj_mask),
        .flip     (flip)
    );

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        rr_vote_cell #(
            .COPIES  (RR_COPIES),
            .RST_BIT (RST_EXT[b])
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_bit    (wr_ext[b]),
            .flip_mask (flip[b]),
            .voted     (voted[b])
        );
    end

    always_comb begin
        rd_data  = voted[WIDTH-1:0];
        mismatch = (^voted[WIDTH-1:0]) != voted[WIDTH];
    end

    rr_alarm_fsm u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .detect  (mismatch),
        .err_clr (err_clr),
        .alarm   (uncorr_err)
    );

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inj_en) |=> (rd_data == $past(wr_data))) else $error("wv"); // R4
    AST_WRITE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inj_en) |=> !mismatch) else $error("wp"); // R5

endmodule

// File: tb/tb_rr_field.sv
module tb_rr_field;
    localparam int unsigned WIDTH = 8;
    localparam logic [WIDTH-1:0] RST = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic inj_en = 1'b0;
    logic [3:0] inj_sel = '0;
    logic [4:0] inj_mask = '0;
    logic err_clr = 1'b0;
    logic uncorr_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rr_field #(.WIDTH(WIDTH), .RST_VAL(RST)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .inj_en(inj_en), .inj_sel(inj_sel),
        .inj_mask(inj_mask), .err_clr(err_clr), .uncorr_err(uncorr_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one edge with the currently driven inputs, then drop the strobes
    task automatic step();
        @(posedge clk);
        #1;
        wr_en = 1'b0; inj_en = 1'b0; inj_mask = '0; err_clr = 1'b0;
    endtask

    task automatic do_write(input logic [WIDTH-1:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
    endtask

    task automatic do_inject(input logic [3:0] sel, input logic [4:0] m);
        inj_en = 1'b1; inj_sel = sel; inj_mask = m;
        step();
    endtask

    task automatic do_clear();
        err_clr = 1'b1;
        step();
    endtask

    task automatic t_reset();
        chk("R9 reset value", rd_data, RST);
        chk("R9 reset alarm", uncorr_err, 0);
        step();
        chk("R9 parity consistent", uncorr_err, 0);
    endtask

    task automatic t_write();
        do_write(8'h07);
        chk("R4 write odd", rd_data, 8'h07);
        step();
        chk("R5 odd parity no alarm", uncorr_err, 0);
        do_write(8'h3C);
        chk("R4 write even", rd_data, 8'h3C);
        step();
        chk("R5 even parity no alarm", uncorr_err, 0);
    endtask

    task automatic t_single();
        do_inject(4'd3, 5'b00001);
        chk("R2 single flip read", rd_data, 8'h3C);
        step();
        chk("R8 single flip no alarm", uncorr_err, 0);
    endtask

    task automatic t_double_scrub();
        do_inject(4'd5, 5'b00011);
        chk("R2 double flip read", rd_data, 8'h3C);
        do_inject(4'd5, 5'b01100);
        chk("R3 scrub between flips", rd_data, 8'h3C);
        step(); step();
        chk("R3 no alarm", uncorr_err, 0);
        chk("R1 vote after scrub", rd_data, 8'h3C);
    endtask

    task automatic t_write_inject();
        wr_en = 1'b1; wr_data = 8'hF0;
        inj_en = 1'b1; inj_sel = 4'd7; inj_mask = 5'b10001;
        step();
        chk("R8 write plus inject read", rd_data, 8'hF0);
        step();
        chk("R8 write plus inject no alarm", uncorr_err, 0);
        do_write(8'h3C);
    endtask

    task automatic t_triple();
        do_inject(4'd0, 5'b00111);
        chk("R6 miscorrected read", rd_data, 8'h3D);
        chk("R6 alarm not yet", uncorr_err, 0);
        step();
        chk("R6 alarm raised", uncorr_err, 1);
        do_clear();
        chk("R7 clear under mismatch", uncorr_err, 1);
        do_write(8'h3C);
        step();
        chk("R7 sticky after repair", uncorr_err, 1);
        do_clear();
        chk("R7 clear releases", uncorr_err, 0);
    endtask

    task automatic t_check_bit();
        do_inject(4'd8, 5'b11100);
        chk("R10 read unchanged", rd_data, 8'h3C);
        step();
        chk("R10 alarm raised", uncorr_err, 1);
        do_write(8'h3C);
        do_clear();
        chk("R10 cleared after rewrite", uncorr_err, 0);
    endtask

    task automatic t_clr_vs_detect();
        do_inject(4'd8, 5'b01110);
        // mismatch present this cycle only; repair and clear at one edge
        wr_en = 1'b1; wr_data = 8'h3C; err_clr = 1'b1;
        step();
        chk("R7 clear loses to detect", uncorr_err, 1);
        step();
        chk("R7 still set", uncorr_err, 1);
        do_clear();
        chk("R7 later clear", uncorr_err, 0);
    endtask

    initial begin
        #100000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #9;
        rst_n = 1'b1;
        #2;
        t_reset();
        t_write();
        t_single();
        t_double_scrub();
        t_write_inject();
        t_triple();
        t_check_bit();
        t_clr_vs_detect();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule